// File: doc/BRIEF.md
# Column-Slice Compressor Tree

This block adds up a large set of single-bit addends of mixed weight and produces one binary sum. It is organised as a row of column slices. Slice i owns the bit column of weight 2^i and reduces it through a fixed cascade: a 15-to-4 counter, then a 4-to-3 counter, then a 3-to-2 counter, and finally one bit of a carry-propagate adder. Each counter's higher-weight outputs are wired directly to the slices above it, so no programmable routing sits between the counters. Beyond the top slice, extra columns with no primary inputs absorb the spill-over bits, so the sum is always exact.

A small shift register holds one enable bit per slice. It is loaded serially, one bit per clock edge, while the load strobe is high. A disabled slice behaves as though all of its column inputs were zero. This lets a shorter tree be mapped onto the array. The reduction datapath is combinational, and the enable register is its only state.

Top module: `colTreeTop`

## Requirements
- R1: `sum` equals the weighted popcount Σ 2^i · (number of ones in `colBits[16*i+14 : 16*i]`) over every enabled slice i, where slice i's bit k is `colBits[16*i+k]`.
- R2: When slice 0 is enabled, `colBits[15]` adds exactly 1 to `sum` and acts as the adder carry-in.
- R3: For slices 1 to 7, input bit 15 (`colBits[16*i+15]`) has no effect on `sum`.
- R4: After reset, all eight slices are enabled, with the enable mask at 8'hFF.
- R5: On each rising clock edge with `cfgLoad` high, the enable mask becomes {`cfgIn`, mask[7:1]}. Mask bit i = 1 enables slice i. After eight loads, the first bit shifted in controls slice 0.
- R6: While `cfgLoad` is low, the enable mask holds its value.
- R7: A disabled slice adds nothing to `sum`, whatever its inputs are. With the mask at 0, `sum` is 0.
- R8: With every input set and every slice enabled, `sum` is 15·255+1 = 3826, and it fits the 12-bit output without overflow.
- R9: `sum` responds to `colBits` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the enable register |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Shift strobe for the enable mask |
| cfgIn | input | 1 | Serial enable bit, entering at slice 7 |
| colBits | input | 128 | Column inputs, 16 per slice, slice i at [16*i+15:16*i] |
| sum | output | 12 | Weighted popcount of the enabled columns |

## Verification
The all-ones vector is the main corner case. A design that drops a spill-over bit above slice 7, or misroutes a weight-3 counter output, returns less than 3826. The sixteenth input is checked separately on slice 0, where a design that ignores the carry-in is off by one, and on higher slices, where a design that counts that bit adds 2^i. The mask is loaded with asymmetric patterns. A shift in the wrong direction, or gating of the wrong slice, then shows up as a wrong weighted sum. Random vectors under partial masks cover the crossing paths between neighbouring slices.

// File: rtl/colTreePkg.sv
package colTreePkg;
  localparam int NUM_SLICES = 8;
  localparam int IN_BITS    = 16;
  localparam int SUM_W      = 12;

  // strobes from the configuration control to the datapath
  typedef struct packed {
    logic [NUM_SLICES-1:0] sliceEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/popCounter.sv
module popCounter #(
  parameter int IN_W  = 15,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  bitsIn,
  output logic [OUT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < IN_W; k++) count = count + OUT_W'(bitsIn[k]);
  end
endmodule

// File: rtl/cfgShift.sv
module cfgShift
  import colTreePkg::*;
#(
  parameter int NSL = NUM_SLICES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgLoad,
  input  logic         cfgIn,
  output ctrlStrobes_t ctrl
);
  logic [NSL-1:0] mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        mask <= '1;
    else if (cfgLoad) mask <= {cfgIn, mask[NSL-1:1]};
  end

  assign ctrl.sliceEn = mask;
endmodule

// File: rtl/colArray.sv
module colArray
  import colTreePkg::*;
#(
  parameter int NSL = NUM_SLICES,
  parameter int INB = IN_BITS,
  parameter int SW  = SUM_W
) (
  input  ctrlStrobes_t       ctrl,
  input  logic [NSL*INB-1:0] colBits,
  output logic [SW-1:0]      sum
);
  localparam int CB   = INB - 1;          // counted bits per column
  localparam int COLS = SW;               // slices plus extension columns
  localparam int L1W  = $clog2(CB + 1);   // 15:4 output width

  logic [NSL*INB-1:0] gated;
  logic [L1W-1:0] s1 [COLS];
  logic [2:0]     s2 [COLS];
  logic [1:0]     s3 [COLS];
  logic [SW-1:0]  addA, addB;
  logic           carryIn;

  generate
    for (genvar i = 0; i < NSL; i++) begin : gGate
      assign gated[i*INB +: INB] = ctrl.sliceEn[i] ? colBits[i*INB +: INB] : '0;
    end

    for (genvar j = 0; j < COLS; j++) begin : gCol
      logic [CB-1:0] colIn;
      logic [3:0]    in43;
      logic [2:0]    in32;

      if (j < NSL) begin : gPrim
        assign colIn = gated[j*INB +: CB];
      end else begin : gExt
        assign colIn = '0;
      end

      popCounter #(.IN_W(CB), .OUT_W(L1W)) u15 (.bitsIn(colIn), .count(s1[j]));

      assign in43[0] = s1[j][0];
      for (genvar k = 1; k < 4; k++) begin : gIn43
        if (j >= k) begin : gW
          assign in43[k] = s1[j-k][k];
        end else begin : gZ
          assign in43[k] = 1'b0;
        end
      end
      popCounter #(.IN_W(4), .OUT_W(3)) u43 (.bitsIn(in43), .count(s2[j]));

      assign in32[0] = s2[j][0];
      for (genvar k = 1; k < 3; k++) begin : gIn32
        if (j >= k) begin : gW
          assign in32[k] = s2[j-k][k];
        end else begin : gZ
          assign in32[k] = 1'b0;
        end
      end
      popCounter #(.IN_W(3), .OUT_W(2)) u32 (.bitsIn(in32), .count(s3[j]));

      assign addA[j] = s3[j][0];
      if (j >= 1) begin : gB
        assign addB[j] = s3[j-1][1];
      end else begin : gB0
        assign addB[j] = 1'b0;
      end
    end
  endgenerate

  assign carryIn = gated[INB-1];
  assign sum     = addA + addB + SW'(carryIn);
endmodule

// File: rtl/colTreeTop.sv
module colTreeTop
  import colTreePkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgLoad,
  input  logic                         cfgIn,
  input  logic [NUM_SLICES*IN_BITS-1:0] colBits,
  output logic [SUM_W-1:0]             sum
);
  ctrlStrobes_t ctrl;

  cfgShift #(.NSL(NUM_SLICES)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn), .ctrl(ctrl)
  );

  colArray #(.NSL(NUM_SLICES), .INB(IN_BITS), .SW(SUM_W)) u_arr (
    .ctrl(ctrl), .colBits(colBits), .sum(sum)
  );
endmodule

// File: rtl/colTreeChk.sv
module colTreeChk
  import colTreePkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgLoad,
  input logic                          cfgIn,
  input logic [NUM_SLICES*IN_BITS-1:0] colBits,
  input logic [NUM_SLICES-1:0]         sliceEn,
  input logic [SUM_W-1:0]              sum
);
  localparam int MAX_SUM = (IN_BITS - 1) * ((1 << NUM_SLICES) - 1) + 1;

  AST_CFG_SHIFT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> sliceEn[NUM_SLICES-1] == $past(cfgIn));                       // R5
  AST_CFG_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> sliceEn[NUM_SLICES-2:0] == $past(sliceEn[NUM_SLICES-1:1]));   // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(sliceEn));                                           // R6
  AST_MASK_OFF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (sliceEn == '0) |-> (sum == '0));                                         // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sum) <= MAX_SUM));                                                  // R8
  AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    ((&colBits) && (&sliceEn)) |-> (int'(sum) == MAX_SUM));                   // R8
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rstN)
    (colBits == '0) |-> (sum == '0));                                         // R1
endmodule

bind colTreeTop colTreeChk u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn),
  .colBits(colBits), .sliceEn(ctrl.sliceEn), .sum(sum)
);

// File: tb/test_colTreeTop.sv
module test_colTreeTop;
  import colTreePkg::*;
  localparam int NB = NUM_SLICES * IN_BITS;

  logic clk = 1'b0, rstN = 1'b0, cfgLoad = 1'b0, cfgIn = 1'b0;
  logic [NB-1:0] colBits = '0;
  logic [SUM_W-1:0] sum;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  colTreeTop i_colTreeTop (.clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
                           .cfgIn(cfgIn), .colBits(colBits), .sum(sum));

  always #2 clk = ~clk;

  typedef struct packed { logic [7:0] mask; logic [NB-1:0] bits; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'hFF, {NB{1'b1}}},
    '{8'h00, {NB{1'b1}}},
    '{8'h01, {NB{1'b1}}},
    '{8'h80, {NB{1'b1}}},
    '{8'hA5, {8{16'h7FFF}}},
    '{8'h3C, {8{16'h5A5A}}}
  };

  function automatic int refSum(logic [7:0] m, logic [NB-1:0] b);
    int s = 0;
    for (int i = 0; i < NUM_SLICES; i++)
      if (m[i]) for (int k = 0; k < IN_BITS - 1; k++) s += int'(b[i*IN_BITS+k]) << i;
    if (m[0]) s += int'(b[IN_BITS-1]);
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadMask(logic [7:0] m);
    for (int k = 0; k < NUM_SLICES; k++) begin
      @(negedge clk); cfgLoad = 1'b1; cfgIn = m[k];
    end
    @(negedge clk); cfgLoad = 1'b0;
  endtask

  task automatic applyCheck(string req, logic [NB-1:0] b, int exp);
    @(negedge clk); colBits = b; #1;
    check(req, int'(sum), exp);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] rb;
    logic [7:0] rm;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R4: reset mask all enabled, observe with all ones
    applyCheck("R4/R8", {NB{1'b1}}, 3826);
    // R9: combinational response
    applyCheck("R9", '0, 0);
    // R2 carry-in
    applyCheck("R2", NB'(1) << 15, 1);
    // R3 slice 3 bit 15 ignored
    applyCheck("R3", NB'(1) << (3*16+15), 0);
    applyCheck("R3", (NB'(1) << (7*16+15)) | (NB'(1) << (7*16)), 128);
    // R1 single bit weights
    applyCheck("R1", NB'(1) << (5*16+4), 32);
    // table walk (R1, R5, R7)
    foreach (VECS[v]) begin
      loadMask(VECS[v].mask);
      applyCheck("R1/R5/R7", VECS[v].bits, refSum(VECS[v].mask, VECS[v].bits));
    end
    // R6: mask held while idle
    loadMask(8'h0F);
    repeat (5) @(negedge clk);
    applyCheck("R6", {NB{1'b1}}, refSum(8'h0F, {NB{1'b1}}));
    // R7: mask zero
    loadMask(8'h00);
    applyCheck("R7", {NB{1'b1}}, 0);
    // R2 with slice 0 disabled
    loadMask(8'hFE);
    applyCheck("R2/R7", NB'(1) << 15, 0);
    // random (R1)
    for (int r = 0; r < 40; r++) begin
      rm = 8'($urandom);
      for (int w = 0; w < NB / 32; w++) rb[w*32 +: 32] = $urandom;
      loadMask(rm);
      applyCheck("R1", rb, refSum(rm, rb));
    end
    // R4 again after reset
    @(negedge clk); rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    applyCheck("R4", {NB{1'b1}}, 3826);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule